// File: doc/BRIEF.md
# DDS Profile Serial Writer

The writer moves a fresh set of per-channel synthesis settings into a bank of DDS devices over a parallel set of serial lanes. Each channel supplies one packed profile word: a frequency tuning word split into low and high halves, a phase offset word and an amplitude scale. When a write is accepted, the words are captured. Each lane then clocks out a fixed command word followed by its share of the profile payload. After a short wait, one update strobe makes every device apply the new values at the same moment.

The upstream filter raises a completion flag once all channels hold valid results. Writes start only when that flag is high, so the profile words are never taken mid-calculation. The duration of a write is fixed by the parameters, so the enclosing loop can plan its iteration period around it.

Top module: `dds_prof_writer`

## Requirements
- R1: A profile word of 4×WORD_W bits is packed with the low frequency half in bits [WORD_W-1:0], the high frequency half above it, the phase word above that, and the amplitude in the top field [4×WORD_W-1:3×WORD_W]. Every field is sent MSB first, so the wire order within a profile is amplitude, phase, high frequency half, low frequency half.
- R2: Channel c belongs to device c/CH_PER_DEV. Channel c occupies `prof_in[c×64 +: 64]` by default. A device's payload is its channels in rising index order, with the lowest index sent first. That payload is split into LANES_PER_DEV equal chunks, and chunk k (counted from the first-sent end) goes to lane `dev×LANES_PER_DEV + k`.
- R3: A frame on every lane is the command word CMD_WORD (16 bits, default 16'h0E16) followed by 128 payload bits, all MSB first.
  - Each bit is held for HALF_DIV clocks with `ser_clk` low and then HALF_DIV clocks with it high.
  - The receiver samples on the rising edge.
  - `ser_cs_n` is low for exactly the frame.
  - `ser_dat` changes only when `ser_clk` falls.
  - `ser_clk` is low whenever `ser_cs_n` is high.
- R4: After the last bit, the writer waits HALF_DIV clocks with `ser_cs_n` high. It then raises `upd_strobe` for exactly one clock.
- R5: `wr_done` is a one-clock pulse in the clock after `upd_strobe`. It rises (2×144+1)×HALF_DIV+1 clock edges after the edge that accepted the start (579 by default).
- R6: `wr_start` is accepted only on an edge where the writer is idle and `calc_done` is high. With `calc_done` low, no frame begins.
- R7: A `wr_start` that arrives while a write is in progress is ignored. It neither changes the current frame nor starts another write afterwards.
- R8: The profile inputs are captured on the accepting edge. Later changes to `prof_in` do not affect the frame in progress.
- R9: After reset, `ser_clk`, `ser_dat`, `upd_strobe` and `wr_done` are low and `ser_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Request one profile write |
| calc_done | input | 1 | Upstream results valid for all channels |
| prof_in | input | NUM_DEV×CH_PER_DEV×4×WORD_W (512) | Packed profile words, channel 0 lowest |
| ser_clk | output | 1 | Serial clock shared by all lanes |
| ser_dat | output | NUM_DEV×LANES_PER_DEV (4) | Serial data lanes |
| ser_cs_n | output | 1 | Active-low frame select |
| upd_strobe | output | 1 | One-clock update strobe for all devices |
| wr_done | output | 1 | One-clock pulse when the write has finished |

## Verification
The accepting edge is the rising edge at which `wr_start` is seen. Timing is counted from there:

| Result | Due |
|---|---|
| First rising `ser_clk` | HALF_DIV edges after the accepting edge |
| Each further bit | 2×HALF_DIV edges after the previous one |
| `upd_strobe` | T−1 edges after the accepting edge |
| `wr_done` | T edges after the accepting edge |

The bench drives inputs on falling edges and samples outputs there too. It counts falling edges from the accepting edge and captures a lane bit whenever it sees `ser_clk` newly high. It therefore checks each result against the exact edge count derived above, not against a window. When the run is idle, it keeps sampling for a fixed span to show that a refused or ignored start produced no frame.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_UPD   = 2'd3
  } dsw_state_e;
endpackage

// File: rtl/dsw_seq.sv
module dsw_seq
  import dsw_pkg::*;
#(
  parameter int FRAME_W  = 144,
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic load,
  output logic shift,
  output logic ser_clk,
  output logic ser_cs_n,
  output logic upd_strobe,
  output logic wr_done
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  dsw_state_e st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitc;
  logic cnt_last, bit_last;

  assign cnt_last = (cnt == CNT_W'(HALF_DIV - 1));
  assign bit_last = (bitc == BIT_W'(FRAME_W - 1));
  assign load     = (st == ST_IDLE) && go;
  // next bit is presented as the serial clock falls, except after the last bit
  assign shift    = (st == ST_SHIFT) && ser_clk && cnt_last && !bit_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      bitc       <= '0;
      ser_clk    <= 1'b0;
      ser_cs_n   <= 1'b1;
      upd_strobe <= 1'b0;
      wr_done    <= 1'b0;
    end else begin
      upd_strobe <= 1'b0;
      wr_done    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st       <= ST_SHIFT;
            ser_cs_n <= 1'b0;
            ser_clk  <= 1'b0;
            cnt      <= '0;
            bitc     <= '0;
          end
        end
        ST_SHIFT: begin
          if (cnt_last) begin
            cnt <= '0;
            if (ser_clk) begin
              ser_clk <= 1'b0;
              if (bit_last) begin
                st       <= ST_WAIT;
                ser_cs_n <= 1'b1;
              end else begin
                bitc <= bitc + 1'b1;
              end
            end else begin
              ser_clk <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_last) begin
            cnt        <= '0;
            st         <= ST_UPD;
            upd_strobe <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st      <= ST_IDLE;
          wr_done <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dsw_lane.sv
module dsw_lane #(
  parameter int FRAME_W = 144
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sdo
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= frame_in;
    else if (shift) sr <= {sr[FRAME_W-2:0], 1'b0};
  end

  assign sdo = sr[FRAME_W-1];
endmodule

// File: rtl/dds_prof_writer.sv
module dds_prof_writer #(
  parameter int          NUM_DEV       = 2,
  parameter int          CH_PER_DEV    = 4,
  parameter int          LANES_PER_DEV = 2,
  parameter int          WORD_W        = 16,
  parameter int          CMD_W         = 16,
  parameter logic [15:0] CMD_WORD      = 16'h0E16,
  parameter int          HALF_DIV      = 2,
  localparam int         PROF_W        = 4 * WORD_W,
  localparam int         NUM_CH        = NUM_DEV * CH_PER_DEV,
  localparam int         LANES         = NUM_DEV * LANES_PER_DEV,
  localparam int         DEV_W         = CH_PER_DEV * PROF_W,
  localparam int         PAY_W         = DEV_W / LANES_PER_DEV,
  localparam int         FRAME_W       = CMD_W + PAY_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_start,
  input  logic                     calc_done,
  input  logic [NUM_CH*PROF_W-1:0] prof_in,
  output logic                     ser_clk,
  output logic [LANES-1:0]         ser_dat,
  output logic                     ser_cs_n,
  output logic                     upd_strobe,
  output logic                     wr_done
);
  logic load, shift;

  dsw_seq #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (wr_start && calc_done),
    .load       (load),
    .shift      (shift),
    .ser_clk    (ser_clk),
    .ser_cs_n   (ser_cs_n),
    .upd_strobe (upd_strobe),
    .wr_done    (wr_done)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [DEV_W-1:0] dev_pay;
    // lowest channel index of the device lands in the first-sent bits
    for (genvar j = 0; j < CH_PER_DEV; j++) begin : g_ch
      assign dev_pay[(CH_PER_DEV-1-j)*PROF_W +: PROF_W] =
        prof_in[(d*CH_PER_DEV + j)*PROF_W +: PROF_W];
    end
    for (genvar k = 0; k < LANES_PER_DEV; k++) begin : g_lane
      logic [FRAME_W-1:0] frame;
      assign frame = {CMD_WORD[CMD_W-1:0], dev_pay[DEV_W-1-k*PAY_W -: PAY_W]};
      dsw_lane #(.FRAME_W(FRAME_W)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift),
        .frame_in (frame),
        .sdo      (ser_dat[d*LANES_PER_DEV + k])
      );
    end
  end
endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             calc_done,
  input logic             ser_clk,
  input logic [LANES-1:0] ser_dat,
  input logic             ser_cs_n,
  input logic             upd_strobe,
  input logic             wr_done
);
  a_r3_clk_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    ser_cs_n |-> !ser_clk);

  a_r3_data_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!ser_cs_n && $past(!ser_cs_n) && !$fell(ser_clk)) |-> $stable(ser_dat));

  a_r4_strobe_outside_frame: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> ser_cs_n);

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe);

  a_r5_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> wr_done);

  a_r5_done_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> $past(upd_strobe));

  a_r6_no_frame_without_calc: assert property (@(posedge clk) disable iff (rst)
    (ser_cs_n && !calc_done) |=> ser_cs_n);
endmodule

bind dds_prof_writer dsw_checker #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .calc_done  (calc_done),
  .ser_clk    (ser_clk),
  .ser_dat    (ser_dat),
  .ser_cs_n   (ser_cs_n),
  .upd_strobe (upd_strobe),
  .wr_done    (wr_done)
);

// File: tb/tb_dds_prof_writer.sv
module tb_dds_prof_writer;
  localparam int          NDEV  = 2;
  localparam int          CPD   = 4;
  localparam int          LPD   = 2;
  localparam int          WW    = 16;
  localparam int          CMDW  = 16;
  localparam logic [15:0] CMD   = 16'h0E16;
  localparam int          HD    = 2;
  localparam int          PW    = 4 * WW;
  localparam int          NCH   = NDEV * CPD;
  localparam int          NL    = NDEV * LPD;
  localparam int          DW    = CPD * PW;
  localparam int          PAYW  = DW / LPD;
  localparam int          FW    = CMDW + PAYW;
  localparam int          TWR   = (2 * FW + 1) * HD + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_start = 1'b0;
  logic calc_done = 1'b1;
  logic [NCH*PW-1:0] prof_in = '0;
  logic ser_clk, ser_cs_n, upd_strobe, wr_done;
  logic [NL-1:0] ser_dat;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dds_prof_writer dut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .calc_done(calc_done),
    .prof_in(prof_in), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_cs_n(ser_cs_n), .upd_strobe(upd_strobe), .wr_done(wr_done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] exp_frame(input logic [NCH*PW-1:0] p, input int lane);
    logic [DW-1:0] dev;
    int d, k;
    d = lane / LPD;
    k = lane % LPD;
    dev = '0;
    for (int j = 0; j < CPD; j++) dev = (dev << PW) | DW'(p[(d*CPD+j)*PW +: PW]);
    dev = dev >> ((LPD - 1 - k) * PAYW);
    return {CMD, dev[PAYW-1:0]};
  endfunction

  function automatic logic [NCH*PW-1:0] rnd_prof();
    logic [NCH*PW-1:0] v;
    v = '0;
    for (int i = 0; i < NCH*PW/32; i++) v = (v << 32) | (NCH*PW)'($urandom);
    return v;
  endfunction

  logic [FW-1:0] got [NL];

  task automatic do_write(input logic [NCH*PW-1:0] p, input bit disturb);
    int n, bits, upd_at, cs_bad;
    bit prev;
    for (int l = 0; l < NL; l++) got[l] = '0;
    n = 0; bits = 0; upd_at = -1; cs_bad = 0; prev = 0;
    prof_in = p;
    wr_start = 1'b1;
    while (n < TWR + 40) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      wr_start = 1'b0;
      if (disturb && n == 40) begin
        wr_start = 1'b1;   // R7: request during a busy write
        prof_in = ~p;      // R8: inputs change mid-write
      end
      if (ser_clk && !prev) begin
        bits++;
        if (ser_cs_n) cs_bad++;
        for (int l = 0; l < NL; l++) got[l] = {got[l][FW-2:0], ser_dat[l]};
      end
      prev = ser_clk;
      if (upd_strobe) upd_at = n;
      if (wr_done) break;
    end
    check(n - 1 == TWR, "R5 write latency", 256'(n - 1), 256'(TWR));
    check(upd_at - 1 == TWR - 1, "R4 strobe edge", 256'(upd_at - 1), 256'(TWR - 1));
    check(bits == FW, "R3 bit count", 256'(bits), 256'(FW));
    check(cs_bad == 0, "R3 select low during bits", 256'(cs_bad), 256'(0));
    for (int l = 0; l < NL; l++) begin
      check(got[l][FW-1 -: CMDW] == CMD, "R3 command word", 256'(got[l][FW-1 -: CMDW]), 256'(CMD));
      check(got[l] == exp_frame(p, l), "R2 R8 lane frame", 256'(got[l]), 256'(exp_frame(p, l)));
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 0) check(!wr_done, "R5 done single pulse", 256'(wr_done), 256'(0));
      if (!ser_cs_n || ser_clk) begin
        check(0, "R7 no extra frame", 256'({ser_cs_n, ser_clk}), 256'(2));
        break;
      end
    end
  endtask

  initial begin
    logic [NCH*PW-1:0] p;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ser_cs_n && !ser_clk && !upd_strobe && !wr_done && ser_dat == '0,
          "R9 reset state", 256'({ser_cs_n, ser_clk, upd_strobe, wr_done, ser_dat}),
          256'({1'b1, 3'b000, NL'(0)}));

    // R1: distinct fields in channel 0, first payload bits on lane 0 are the amplitude
    p = '0;
    p[PW-1:0] = {16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F};
    do_write(p, 0);
    check(got[0][PAYW-1 -: PW] == {16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F},
          "R1 field wire order", 256'(got[0][PAYW-1 -: PW]),
          256'({16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F}));

    do_write(rnd_prof(), 0);
    do_write(rnd_prof(), 1);   // R7 R8

    // R6: start refused while calculation not finished
    calc_done = 1'b0;
    @(negedge clk);
    wr_start = 1'b1;
    @(negedge clk);
    wr_start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!ser_cs_n) begin
        check(0, "R6 refused start", 256'(ser_cs_n), 256'(1));
        break;
      end
    end
    check(ser_cs_n && !wr_done, "R6 still idle", 256'({ser_cs_n, wr_done}), 256'(2));
    calc_done = 1'b1;

    do_write('1, 0);
    do_write('0, 0);
    for (int r = 0; r < 3; r++) do_write(rnd_prof(), r == 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule